// File: doc/BRIEF.md
# Configurable Asynchronous Serial Framer

This block is a transmitter and receiver pair for an asynchronous serial line. Framing is set by static control inputs: one or two stop bits, optional even or odd parity, and a multiprocessor format. In that format a flag bit marks each character as an address or a data character. A shared tick generator divides the system clock first by a selectable prescale tap and then by a programmable rate count. It produces sixteen oversample ticks per bit period.

Bytes enter the transmitter through a valid/ready handshake and leave on `txd` least significant bit first. The receiver synchronises `rxd`, qualifies each start edge at the middle of the start bit, and samples every later bit at its centre. It delivers each character with a one-cycle strobe that carries its error flags. The receiver checks only the first stop bit. When a low level follows one good stop bit, the receiver takes it as the start of the next character, whatever the stop-length setting is.

Top module: `async_framer`

## Requirements
- R1: While idle, `txd` is high and `tx_ready` is high. An accepted byte is sent as a low start bit followed by the 8 data bits, least significant bit first. Every bit lasts 16 oversample ticks, and `tx_ready` is low until the character is finished.
- R2: With `cfg_two_stop`=0 the transmitter ends each character with one high bit. With `cfg_two_stop`=1 it ends each character with two high bits.
- R3: `cfg_clk_sel` codes 0, 1, 2 and 3 divide the clock by 1, 4, 16 and 64. One bit period is that divisor times (`cfg_rate`+1) times 16 clock cycles, counted from reset.
- R4: When `cfg_par_en`=1 and `cfg_mp_en`=0, one parity bit follows the data. With `cfg_par_odd`=0 the number of ones over data and parity is even. With `cfg_par_odd`=1 that number is odd.
- R5: When `cfg_mp_en`=1, one flag bit follows the data, taken from `tx_mp` (1 = address, 0 = data). The receiver reports this bit on `rx_mp`. On both sides `cfg_par_en` and `cfg_par_odd` have no effect, and `rx_parity_err` stays 0.
- R6: When `cfg_par_en`=0 and `cfg_mp_en`=0, the stop bits follow the data directly, and `rx_mp` and `rx_parity_err` are 0.
- R7: The receiver accepts a start bit only if the line is still low at the start bit's middle sample. A shorter low pulse produces no character.
- R8: The receiver checks only the first stop bit. If that bit is low, `rx_frame_err` is set. A low bit right after one good stop bit starts the next character without an error, even with `cfg_two_stop`=1.
- R9: In parity mode, a received parity bit that does not match the selected sense sets `rx_parity_err`.
- R10: Each received character raises `rx_valid` for exactly one cycle. `rx_data`, `rx_mp` and both error flags are valid in that cycle.
- R11: After a framing error, the receiver ignores the line until it has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_two_stop | input | 1 | 0: one stop bit, 1: two stop bits (transmit) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_mp_en | input | 1 | Multiprocessor format enable |
| cfg_clk_sel | input | 2 | Prescale tap: /1, /4, /16, /64 |
| cfg_rate | input | 8 | Rate count N; tick every prescaled clock times (N+1) |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_mp | input | 1 | Address/data flag sent in multiprocessor format |
| tx_ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_data | output | 8 | Received byte |
| rx_mp | output | 1 | Received address/data flag |
| rx_frame_err | output | 1 | First stop bit was low |
| rx_parity_err | output | 1 | Parity mismatch |

## Verification
The assertions check these properties on every cycle: the start bit goes low and `tx_ready` drops right after each accept, prescale ticks stay spaced apart for every divisor above one, a rejected start returns the receiver to idle, the receiver stays parked while the line is low after a bad stop bit, the receive strobe lasts one cycle, and no parity error is reported alongside a multiprocessor flag. Only the bench scenarios can show the full serial waveform compared bit by bit against a reference at every prescale tap, the parity sense, the back-to-back character that starts in a second stop-bit slot, and glitch rejection. The same holds for loopback of the address flag.

// File: rtl/afr_pkg.sv
package afr_pkg;
  localparam int AFR_DATA_W = 8;
  localparam int AFR_OSR    = 16;
  localparam int AFR_SUB_W  = $clog2(AFR_OSR);
  localparam int AFR_IDX_W  = $clog2(AFR_DATA_W);
  localparam int AFR_PRE_W  = 6;
  localparam int AFR_RATE_W = 8;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_EXTRA, TX_STOP1, TX_STOP2
  } afr_tx_st_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_EXTRA, RX_STOP, RX_HOLD
  } afr_rx_st_e;

  // Last prescale count for a tap code: 4**sel - 1
  function automatic logic [AFR_PRE_W-1:0] afr_pre_last(input logic [1:0] sel);
    logic [AFR_PRE_W:0] div;
    div = (AFR_PRE_W+1)'(1) << (2 * sel);
    return AFR_PRE_W'(div - 1'b1);
  endfunction

  // Bit placed after the data: flag in multiprocessor format, else parity
  function automatic logic afr_extra_bit(input logic [AFR_DATA_W-1:0] d,
                                         input logic mp_en, input logic mp_bit,
                                         input logic odd);
    return mp_en ? mp_bit : ((^d) ^ odd);
  endfunction
endpackage

// File: rtl/afr_tick_gen.sv
module afr_tick_gen
  import afr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            clk_sel,
  input  logic [AFR_RATE_W-1:0] rate,
  output logic                  os_tick
);
  logic [AFR_PRE_W-1:0]  pre_q;
  logic [AFR_RATE_W-1:0] rate_q;
  logic [AFR_PRE_W-1:0]  pre_last;
  logic                  pre_tick;
  logic                  rate_wrap;

  always_comb begin
    pre_last  = afr_pre_last(clk_sel);
    pre_tick  = (pre_q >= pre_last);
    rate_wrap = (rate_q >= rate);
    os_tick   = pre_tick && rate_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      rate_q <= '0;
    end else begin
      pre_q <= pre_tick ? '0 : pre_q + 1'b1;
      if (pre_tick) rate_q <= rate_wrap ? '0 : rate_q + 1'b1;
    end
  end

  AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick && (pre_last != '0) |=> !pre_tick || !$stable(clk_sel)); // R3
endmodule

// File: rtl/afr_tx.sv
module afr_tx
  import afr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  os_tick,
  input  logic                  two_stop,
  input  logic                  par_en,
  input  logic                  par_odd,
  input  logic                  mp_en,
  input  logic                  in_valid,
  input  logic [AFR_DATA_W-1:0] in_data,
  input  logic                  in_mp,
  output logic                  in_ready,
  output logic                  txd
);
  localparam logic [AFR_SUB_W-1:0] SUB_LAST = AFR_SUB_W'(AFR_OSR - 1);
  localparam logic [AFR_IDX_W-1:0] IDX_LAST = AFR_IDX_W'(AFR_DATA_W - 1);

  afr_tx_st_e            state_q;
  logic [AFR_DATA_W-1:0] shreg_q;
  logic [AFR_SUB_W-1:0]  sub_q;
  logic [AFR_IDX_W-1:0]  idx_q;
  logic                  extra_q, has_extra_q, two_q;
  logic                  tx_accept, bit_end;

  assign in_ready  = (state_q == TX_IDLE);
  assign tx_accept = in_valid && in_ready;
  assign bit_end   = os_tick && (sub_q == SUB_LAST);

  always_comb begin
    case (state_q)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = shreg_q[0];
      TX_EXTRA: txd = extra_q;
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= TX_IDLE;
      shreg_q     <= '0;
      sub_q       <= '0;
      idx_q       <= '0;
      extra_q     <= 1'b0;
      has_extra_q <= 1'b0;
      two_q       <= 1'b0;
    end else if (tx_accept) begin
      state_q     <= TX_START;
      shreg_q     <= in_data;
      sub_q       <= '0;
      extra_q     <= afr_extra_bit(in_data, mp_en, in_mp, par_odd);
      has_extra_q <= mp_en | par_en;
      two_q       <= two_stop;
    end else if (state_q != TX_IDLE && os_tick) begin
      sub_q <= sub_q + 1'b1;
      if (bit_end) begin
        case (state_q)
          TX_START: begin
            state_q <= TX_DATA;
            idx_q   <= '0;
          end
          TX_DATA: begin
            shreg_q <= shreg_q >> 1;
            idx_q   <= idx_q + 1'b1;
            if (idx_q == IDX_LAST) state_q <= has_extra_q ? TX_EXTRA : TX_STOP1;
          end
          TX_EXTRA: state_q <= TX_STOP1;
          TX_STOP1: state_q <= two_q ? TX_STOP2 : TX_IDLE;
          default:  state_q <= TX_IDLE;
        endcase
      end
    end
  end

  AST_ACCEPT_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> !txd); // R1
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> !in_ready); // R1
endmodule

// File: rtl/afr_rx.sv
module afr_rx
  import afr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  os_tick,
  input  logic                  par_en,
  input  logic                  par_odd,
  input  logic                  mp_en,
  input  logic                  rxd,
  output logic                  out_valid,
  output logic [AFR_DATA_W-1:0] out_data,
  output logic                  out_mp,
  output logic                  out_ferr,
  output logic                  out_perr
);
  localparam logic [AFR_SUB_W-1:0] SUB_LAST  = AFR_SUB_W'(AFR_OSR - 1);
  localparam logic [AFR_SUB_W-1:0] SAMPLE_AT = AFR_SUB_W'(AFR_OSR / 2 - 1);
  localparam logic [AFR_IDX_W-1:0] IDX_LAST  = AFR_IDX_W'(AFR_DATA_W - 1);

  afr_rx_st_e            state_q;
  logic [1:0]            sync_q;
  logic [AFR_SUB_W-1:0]  sub_q;
  logic [AFR_IDX_W-1:0]  idx_q;
  logic [AFR_DATA_W-1:0] shreg_q;
  logic                  extra_q, use_extra_q, mp_q, odd_q;
  logic                  line, sample, bit_end, start_reject, rx_emit, counting;

  assign line         = sync_q[1];
  assign sample       = os_tick && (sub_q == SAMPLE_AT);
  assign bit_end      = os_tick && (sub_q == SUB_LAST);
  assign start_reject = (state_q == RX_START) && sample && line;
  assign rx_emit      = (state_q == RX_STOP) && sample;
  assign counting     = (state_q != RX_IDLE) && (state_q != RX_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= 2'b11;
      state_q     <= RX_IDLE;
      sub_q       <= '0;
      idx_q       <= '0;
      shreg_q     <= '0;
      extra_q     <= 1'b0;
      use_extra_q <= 1'b0;
      mp_q        <= 1'b0;
      odd_q       <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_mp      <= 1'b0;
      out_ferr    <= 1'b0;
      out_perr    <= 1'b0;
    end else begin
      sync_q    <= {sync_q[0], rxd};
      out_valid <= 1'b0;
      if (counting && os_tick) sub_q <= sub_q + 1'b1;
      case (state_q)
        RX_IDLE: if (!line) begin
          state_q     <= RX_START;
          sub_q       <= '0;
          use_extra_q <= par_en | mp_en;
          mp_q        <= mp_en;
          odd_q       <= par_odd;
        end
        RX_START: begin
          if (start_reject) state_q <= RX_IDLE;
          else if (bit_end) begin
            state_q <= RX_DATA;
            idx_q   <= '0;
          end
        end
        RX_DATA: begin
          if (sample) shreg_q <= {line, shreg_q[AFR_DATA_W-1:1]};
          if (bit_end) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_LAST) state_q <= use_extra_q ? RX_EXTRA : RX_STOP;
          end
        end
        RX_EXTRA: begin
          if (sample) extra_q <= line;
          if (bit_end) state_q <= RX_STOP;
        end
        RX_STOP: if (rx_emit) begin
          out_valid <= 1'b1;
          out_data  <= shreg_q;
          out_mp    <= mp_q & extra_q;
          out_ferr  <= !line;
          out_perr  <= use_extra_q && !mp_q &&
                       (extra_q != afr_extra_bit(shreg_q, 1'b0, 1'b0, odd_q));
          state_q   <= line ? RX_IDLE : RX_HOLD;
        end
        RX_HOLD: if (line) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  AST_GLITCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> (state_q == RX_IDLE)); // R7
  AST_HOLD_LOW_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_HOLD) && !line |=> (state_q == RX_HOLD)); // R11
  AST_FERR_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ferr |-> (state_q == RX_HOLD) || (state_q == RX_IDLE)); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R10
  AST_MP_NO_PERR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mp |-> !out_perr); // R5
endmodule

// File: rtl/async_framer.sv
module async_framer
  import afr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_two_stop,
  input  logic                  cfg_par_en,
  input  logic                  cfg_par_odd,
  input  logic                  cfg_mp_en,
  input  logic [1:0]            cfg_clk_sel,
  input  logic [AFR_RATE_W-1:0] cfg_rate,
  input  logic                  tx_valid,
  input  logic [AFR_DATA_W-1:0] tx_data,
  input  logic                  tx_mp,
  output logic                  tx_ready,
  output logic                  txd,
  input  logic                  rxd,
  output logic                  rx_valid,
  output logic [AFR_DATA_W-1:0] rx_data,
  output logic                  rx_mp,
  output logic                  rx_frame_err,
  output logic                  rx_parity_err
);
  logic os_tick;

  afr_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .clk_sel(cfg_clk_sel), .rate(cfg_rate), .os_tick(os_tick)
  );

  afr_tx u_tx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .two_stop(cfg_two_stop),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .mp_en(cfg_mp_en),
    .in_valid(tx_valid), .in_data(tx_data), .in_mp(tx_mp), .in_ready(tx_ready), .txd(txd)
  );

  afr_rx u_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .mp_en(cfg_mp_en), .rxd(rxd),
    .out_valid(rx_valid), .out_data(rx_data), .out_mp(rx_mp),
    .out_ferr(rx_frame_err), .out_perr(rx_parity_err)
  );
endmodule

// File: tb/async_framer_tb_top.sv
module async_framer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_two_stop = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_mp_en = 1'b0;
  logic [1:0] cfg_clk_sel = 2'd0;
  logic [7:0] cfg_rate = 8'd0;
  logic       tx_valid = 1'b0, tx_mp = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_ready, txd, rx_valid, rx_mp, rx_frame_err, rx_parity_err;
  logic [7:0] rx_data;
  logic       rx_drv = 1'b1;
  logic       loop_en = 1'b0;
  logic       rxd_w;

  int checks = 0, failures = 0;
  int period = 1;

  always #2 clk = ~clk;   // 250 MHz

  assign rxd_w = loop_en ? txd : rx_drv;

  async_framer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_mp_en(cfg_mp_en), .cfg_clk_sel(cfg_clk_sel),
    .cfg_rate(cfg_rate), .tx_valid(tx_valid), .tx_data(tx_data), .tx_mp(tx_mp),
    .tx_ready(tx_ready), .txd(txd), .rxd(rxd_w), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_mp(rx_mp), .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Behavioural transmit reference: a queue of line levels, 16 ticks each
  int m_cnt = 0, m_sub = 0, ones = 0;
  bit m_busy = 0, m_tick = 0;
  bit m_bits[$];
  logic [10:0] exp_q[$];   // {parity_err, frame_err, mp, data}

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sub = 0; m_busy = 0; m_bits.delete();
    end else begin
      m_tick = (m_cnt == period - 1);
      m_cnt  = m_tick ? 0 : m_cnt + 1;
      if (m_busy) begin
        if (m_tick) begin
          m_sub++;
          if (m_sub == 16) begin
            m_sub = 0;
            void'(m_bits.pop_front());
            if (m_bits.size() == 0) m_busy = 0;
          end
        end
      end else if (tx_valid) begin
        m_bits.push_back(1'b0);
        ones = 0;
        for (int i = 0; i < 8; i++) begin
          m_bits.push_back(tx_data[i]);
          if (tx_data[i]) ones++;
        end
        if (cfg_mp_en) m_bits.push_back(tx_mp);
        else if (cfg_par_en) m_bits.push_back(((ones % 2) == 1) != cfg_par_odd);
        m_bits.push_back(1'b1);
        if (cfg_two_stop) m_bits.push_back(1'b1);
        m_busy = 1; m_sub = 0;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(txd === (m_busy ? m_bits[0] : 1'b1), "R1 R2 R3 R4 R5 R6", "txd",
          32'(txd), 32'(m_busy ? m_bits[0] : 1'b1));
      chk(tx_ready === !m_busy, "R1 R2", "tx_ready", 32'(tx_ready), 32'(!m_busy));
      if (rx_valid) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R7 R10", "unexpected rx char", 32'({rx_parity_err, rx_frame_err, rx_mp, rx_data}), 32'h0);
        else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          chk({rx_parity_err, rx_frame_err, rx_mp, rx_data} === e, "R5 R6 R8 R9 R10",
              "rx char", 32'({rx_parity_err, rx_frame_err, rx_mp, rx_data}), 32'(e));
        end
      end
    end
  end

  task automatic setup(input logic [1:0] sel, input logic [7:0] rate, input bit two,
                       input bit pe, input bit odd, input bit mp, input bit loop);
    int div;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_clk_sel = sel; cfg_rate = rate; cfg_two_stop = two;
    cfg_par_en = pe; cfg_par_odd = odd; cfg_mp_en = mp; loop_en = loop;
    rx_drv = 1'b1; tx_valid = 1'b0;
    div = 1;
    for (int k = 0; k < sel; k++) div = div * 4;
    period = div * (rate + 1);
    exp_q.delete();
    repeat (2) @(negedge clk);
    chk(txd === 1'b1, "R1", "txd in reset", 32'(txd), 32'h1);
    chk(tx_ready === 1'b1, "R1", "tx_ready in reset", 32'(tx_ready), 32'h1);
    chk(rx_valid === 1'b0, "R10", "rx_valid in reset", 32'(rx_valid), 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic send_tx(input logic [7:0] d, input bit mpb);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d; tx_mp = mpb;
    if (loop_en) exp_q.push_back({1'b0, 1'b0, cfg_mp_en ? mpb : 1'b0, d});
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drive_bit(input bit v);
    rx_drv = v;
    repeat (16 * period) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] d, input bit has_extra, input bit extra,
                             input bit stop_v);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (has_extra) drive_bit(extra);
    drive_bit(stop_v);
  endtask

  task automatic finish_scn(input string req);
    while (m_busy) @(negedge clk);
    rx_drv = 1'b1;
    repeat (32 * period) @(negedge clk);
    chk(exp_q.size() == 0, req, "characters still expected", 32'(exp_q.size()), 32'h0);
  endtask

  task automatic run_all();
    // R1 R6 R3: divide by 1, one stop bit, plain framing, loopback
    setup(2'd0, 8'd0, 0, 0, 0, 0, 1);
    send_tx(8'hA5, 0);
    send_tx(8'h3C, 0);
    finish_scn("R1 R6");
    // R2 R4 R3: divide by 4 with rate 1, two stop bits, even parity
    setup(2'd1, 8'd1, 1, 1, 0, 0, 1);
    send_tx(8'h5A, 0);
    send_tx(8'h01, 0);
    finish_scn("R2 R4");
    // R4 R3: divide by 16, odd parity
    setup(2'd2, 8'd0, 0, 1, 1, 0, 1);
    send_tx(8'hFF, 0);
    send_tx(8'h00, 0);
    finish_scn("R4");
    // R5 R3: divide by 64, multiprocessor format with parity controls set
    setup(2'd3, 8'd0, 0, 1, 1, 1, 1);
    send_tx(8'h81, 1);
    send_tx(8'h7E, 0);
    finish_scn("R5");
    // R8: two-stop setting, next start right after the first stop bit
    setup(2'd0, 8'd0, 1, 0, 0, 0, 0);
    exp_q.push_back({3'b000, 8'h33});
    exp_q.push_back({3'b000, 8'hC4});
    drive_frame(8'h33, 0, 0, 1);
    drive_frame(8'hC4, 0, 0, 1);
    finish_scn("R8");
    // R8 R11: low first stop bit, line kept low, then a good character
    setup(2'd1, 8'd0, 0, 0, 0, 0, 0);
    exp_q.push_back({3'b010, 8'h55});
    exp_q.push_back({3'b000, 8'h12});
    drive_frame(8'h55, 0, 0, 0);
    drive_bit(1'b0);
    drive_bit(1'b0);
    drive_bit(1'b1);
    drive_frame(8'h12, 0, 0, 1);
    finish_scn("R8 R11");
    // R9: even parity, 0x07 needs parity 1; send 0 then a correct one
    setup(2'd0, 8'd0, 0, 1, 0, 0, 0);
    exp_q.push_back({3'b100, 8'h07});
    exp_q.push_back({3'b000, 8'h07});
    drive_frame(8'h07, 1, 0, 1);
    drive_frame(8'h07, 1, 1, 1);
    finish_scn("R9");
    // R5: multiprocessor receive ignores parity controls
    setup(2'd0, 8'd0, 0, 1, 1, 1, 0);
    exp_q.push_back({3'b001, 8'h07});
    exp_q.push_back({3'b000, 8'h80});
    drive_frame(8'h07, 1, 1, 1);
    drive_frame(8'h80, 1, 0, 1);
    finish_scn("R5");
    // R7: short low pulse is rejected, next character arrives intact
    setup(2'd0, 8'd0, 0, 0, 0, 0, 0);
    exp_q.push_back({3'b000, 8'h9D});
    rx_drv = 1'b0;
    repeat (4) @(negedge clk);
    rx_drv = 1'b1;
    repeat (48) @(negedge clk);
    drive_frame(8'h9D, 0, 0, 1);
    finish_scn("R7");
  endtask

  initial begin
    bit wd;
    wd = 0;
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd) chk(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule